// File: doc/BRIEF.md
# Four-Channel DMA Controller Register Interface

This block is the processor-side register file of a four-channel DMA controller. A processor reaches it through a small port window with one-cycle read and write strobes. Each channel has a 16-bit base address and a 16-bit base count, reached as pairs of byte accesses. The controller side holds a command byte, per-channel mode bytes, a four-bit mask, and a status byte made of request and terminal-count bits. One byte pointer is shared by all eight channel ports and selects which half of a 16-bit register the next access touches.

A separate service engine, outside this block, performs the transfers. It reads the mask, request, mode and current-address state from this block. It reports back through two kinds of input: a per-channel progress count and per-channel terminal-count pulses. The readback of a channel register is not stored. It is formed from the current address, the progress count and the count direction. The `SHIFT` parameter selects the byte-wide instance (0) or the word-wide instance (1). It shifts both the port decode and the address and count values.

No data stream crosses this block, so it has no valid/ready handshake. All pins are plain control and status signals. `bus_rdata` is combinational and is valid while `bus_rd` is high. The side effects of a read take place at the clock edge that ends the strobe.

Top module: `dmareg_top`

## Requirements
- R1: The port index is `(bus_addr >> SHIFT) & 0xF`. Indices 0 to 7 select channel `index>>1`. Within a channel, `index&1` picks the register: 0 is the address register and 1 is the count register. Indices 8 to 15 select controller registers.
- R2: Every read or write strobe at indices 0 to 7 toggles the shared byte pointer exactly once. An access made while the pointer is 0 works on the low byte. An access made while it is 1 works on the high byte.
- R3: A high-byte write to a channel reloads that channel's current address with `base_address << SHIFT` and clears its progress count to zero. The reload happens whether the write targets the address register or the count register. The current address appears on `eng_cur_addr`.
- R4: The address register reads back as current address plus progress. When mode bit 5 is set, it reads back as current address minus progress instead. The count register reads back as `(base_count << SHIFT) - progress`. The byte returned is `(value >> (SHIFT + 8*pointer)) & 0xFF`.
- R5: A write to index 8 loads the command byte only when the data is 0x00 or 0x04. Any other value leaves the command unchanged. The command appears on `ctl_command`.
- R6: A write to index 9 sets or clears the request bit of channel `data[1:0]` according to `data[2]`. The same write clears that channel's terminal-count bit. The request bits appear on `eng_req`.
- R7: The mask can be changed three ways. A write to index 10 sets (`data[2]`=1) or clears the mask bit of channel `data[1:0]`. A write to index 14 clears all mask bits. A write to index 15 loads the mask from `data[3:0]`. The mask appears on `eng_mask`.
- R8: A write to index 11 stores the whole data byte as the mode of channel `data[1:0]`. Channel c's mode appears on `eng_mode[8c+7:8c]`.
- R9: A write to index 12 clears the byte pointer. A write to index 13 performs a master reset: pointer cleared, mask 0xF, status and command 0. Power-on reset gives the same state and also clears all channel registers.
- R10: A read of index 8 returns the status byte {request[3:0], terminal_count[3:0]} and then clears the terminal-count bits. A read of index 15 returns {4'b0, mask}. Reads of indices 9 to 14 return 0.
- R11: A pulse on `eng_tc[c]` sets terminal-count bit c. The bit is still set after a status read made in the same cycle.
- R12: The strobe `eng_prog_we[c]` loads channel c's progress count from `eng_prog`. A high-byte write to the same channel in the same cycle wins, and progress becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4+SHIFT | Port address |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during `bus_rd` |
| eng_prog_we | input | 4 | Per-channel progress load strobe |
| eng_prog | input | 4*(17+SHIFT) | Per-channel progress values |
| eng_tc | input | 4 | Per-channel terminal-count pulses |
| eng_mask | output | 4 | Channel mask bits |
| eng_req | output | 4 | Channel request bits |
| eng_mode | output | 32 | Per-channel mode bytes |
| eng_cur_addr | output | 4*(16+SHIFT) | Per-channel current addresses |
| ctl_command | output | 8 | Command byte |

## Verification
The assertions check four things on every cycle:
- each channel access flips the byte pointer;
- a rejected command byte leaves the command unchanged;
- a terminal-count pulse survives a simultaneous status read;
- a high-byte write zeroes progress even against a concurrent progress load.

Only the bench scenarios can show the arithmetic of the readback. This covers the increment and decrement forms, the count subtraction and the byte selection after the word shift. The scenarios also cover the decode of every controller index and the full set of 256 command values. The bench runs a byte-wide and a word-wide instance side by side on the same stimulus.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  localparam int NCH    = 4;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 16;

  typedef struct packed {
    logic       chan_wr;
    logic       chan_rd;
    logic [1:0] ch;
    logic       sel_cnt;
    logic [7:0] ctl_wr;   // bit k: write to index 8+k
    logic       stat_rd;
    logic       mask_rd;
  } dec_t;
endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
  import dmareg_pkg::*;
#(
  parameter int SHIFT = 0
) (
  input  logic [4+SHIFT-1:0] addr,
  input  logic               wr,
  input  logic               rd,
  output dec_t               dec
);
  logic [3:0] idx;
  assign idx = addr[SHIFT +: 4];

  always_comb begin
    dec         = '0;
    dec.ch      = idx[2:1];
    dec.sel_cnt = idx[0];
    dec.chan_wr = wr && !idx[3];
    dec.chan_rd = rd && !idx[3];
    for (int k = 0; k < 8; k++)
      dec.ctl_wr[k] = wr && idx[3] && (idx[2:0] == 3'(k));
    dec.stat_rd = rd && (idx == 4'd8);
    dec.mask_rd = rd && (idx == 4'd15);
  end
endmodule

// File: rtl/dmareg_ctrl.sv
module dmareg_ctrl
  import dmareg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  dec_t           dec,
  input  logic [7:0]     wdata,
  input  logic [NCH-1:0] tc_pulse,
  output logic           ptr,
  output logic [NCH-1:0] mask,
  output logic [NCH-1:0] req,
  output logic [NCH-1:0] tc,
  output logic [7:0]     command,
  output logic [7:0]     ctl_rdata
);
  logic           ptr_n;
  logic [NCH-1:0] mask_n, req_n, tc_n;
  logic [7:0]     cmd_n;
  logic           mreset;

  assign mreset = dec.ctl_wr[5];

  always_comb begin
    ptr_n  = ptr;
    mask_n = mask;
    req_n  = req;
    tc_n   = tc;
    cmd_n  = command;
    if (dec.chan_wr || dec.chan_rd) ptr_n = ~ptr;
    if (dec.ctl_wr[4]) ptr_n = 1'b0;
    if (dec.ctl_wr[0] && ((wdata & 8'hFB) == 8'h00)) cmd_n = wdata;
    if (dec.ctl_wr[1]) begin
      req_n[wdata[1:0]] = wdata[2];
      tc_n[wdata[1:0]]  = 1'b0;
    end
    if (dec.ctl_wr[2]) mask_n[wdata[1:0]] = wdata[2];
    if (dec.ctl_wr[6]) mask_n = '0;
    if (dec.ctl_wr[7]) mask_n = wdata[NCH-1:0];
    if (dec.stat_rd)   tc_n = '0;
    tc_n = tc_n | tc_pulse;
    if (mreset) begin
      ptr_n  = 1'b0;
      mask_n = '1;
      req_n  = '0;
      tc_n   = '0;
      cmd_n  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= 1'b0;
      mask    <= '1;
      req     <= '0;
      tc      <= '0;
      command <= '0;
    end else begin
      ptr     <= ptr_n;
      mask    <= mask_n;
      req     <= req_n;
      tc      <= tc_n;
      command <= cmd_n;
    end
  end

  always_comb begin
    ctl_rdata = '0;
    if (dec.stat_rd)      ctl_rdata = {req, tc};
    else if (dec.mask_rd) ctl_rdata = {4'b0, mask};
  end

  assert_ptr_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.chan_wr || dec.chan_rd) |=> (ptr != $past(ptr)));

  assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.ctl_wr[0] && ((wdata & 8'hFB) != 8'h00)) |=> $stable(command));

  assert_tc_survive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((tc_pulse != '0) && !mreset) |=> ((tc & $past(tc_pulse)) == $past(tc_pulse)));

  assert_master_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mreset |=> (mask == '1 && command == '0 && !ptr && tc == '0));
endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
  import dmareg_pkg::*;
#(
  parameter int SHIFT = 0,
  localparam int CUR_W = REG_W + SHIFT,
  localparam int VW    = REG_W + SHIFT + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  logic             sel_cnt,
  input  logic             ptr,
  input  logic [7:0]       wdata,
  input  logic             mode_we,
  input  logic             prog_we,
  input  logic [VW-1:0]    prog_in,
  output logic [CUR_W-1:0] cur_addr,
  output logic [7:0]       mode,
  output logic [7:0]       rd_byte
);
  logic [REG_W-1:0] base_addr, base_cnt, new_base;
  logic [VW-1:0]    prog, addr_val, cnt_val, val, shifted;
  logic             hi_wr;

  assign hi_wr    = wr_sel && ptr;
  assign new_base = sel_cnt ? base_addr : {wdata, base_addr[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      prog      <= '0;
      mode      <= '0;
    end else begin
      if (wr_sel && !ptr) begin
        if (sel_cnt) base_cnt[7:0]  <= wdata;
        else         base_addr[7:0] <= wdata;
      end
      if (hi_wr) begin
        if (sel_cnt) base_cnt[15:8]  <= wdata;
        else         base_addr[15:8] <= wdata;
        cur_addr <= CUR_W'(new_base) << SHIFT;
        prog     <= '0;
      end else if (prog_we) begin
        prog <= prog_in;
      end
      if (mode_we) mode <= wdata;
    end
  end

  always_comb begin
    addr_val = mode[5] ? (VW'(cur_addr) - prog) : (VW'(cur_addr) + prog);
    cnt_val  = (VW'(base_cnt) << SHIFT) - prog;
    val      = sel_cnt ? cnt_val : addr_val;
    shifted  = val >> (SHIFT + (ptr ? 8 : 0));
    rd_byte  = shifted[7:0];
  end

  assert_reload_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> (prog == '0));

  assert_prog_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_we && !hi_wr) |=> (prog == $past(prog_in)));
endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
  import dmareg_pkg::*;
#(
  parameter int SHIFT = 0,
  localparam int AW    = 4 + SHIFT,
  localparam int CUR_W = REG_W + SHIFT,
  localparam int PW    = REG_W + SHIFT + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic [NCH-1:0]     eng_prog_we,
  input  logic [NCH*PW-1:0]  eng_prog,
  input  logic [NCH-1:0]     eng_tc,
  output logic [NCH-1:0]     eng_mask,
  output logic [NCH-1:0]     eng_req,
  output logic [NCH*8-1:0]   eng_mode,
  output logic [NCH*CUR_W-1:0] eng_cur_addr,
  output logic [7:0]         ctl_command
);
  dec_t       dec;
  logic       ptr;
  logic [NCH-1:0] tc;
  logic [7:0] ctl_rdata;
  logic [7:0] chan_byte [NCH];

  dmareg_decode #(.SHIFT(SHIFT)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .dec(dec)
  );

  dmareg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .dec(dec), .wdata(bus_wdata),
    .tc_pulse(eng_tc), .ptr(ptr), .mask(eng_mask), .req(eng_req),
    .tc(tc), .command(ctl_command), .ctl_rdata(ctl_rdata)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dmareg_chan #(.SHIFT(SHIFT)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_sel(dec.chan_wr && (dec.ch == 2'(c))),
      .sel_cnt(dec.sel_cnt), .ptr(ptr), .wdata(bus_wdata),
      .mode_we(dec.ctl_wr[3] && (bus_wdata[1:0] == 2'(c))),
      .prog_we(eng_prog_we[c]), .prog_in(eng_prog[c*PW +: PW]),
      .cur_addr(eng_cur_addr[c*CUR_W +: CUR_W]),
      .mode(eng_mode[c*8 +: 8]), .rd_byte(chan_byte[c])
    );
  end

  assign bus_rdata = dec.chan_rd ? chan_byte[dec.ch] : ctl_rdata;

  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));
endmodule

// File: tb/sim_dmareg_top.sv
`timescale 1ns/1ps
module sim_dmareg_top;
  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic [3:0] idx_q = 0;
  logic       lsb_q = 0;
  logic       wr = 0, rd = 0;
  logic [7:0] wd = 0;
  logic [3:0] pwe = 0, tcv = 0;
  int         pval [4];
  logic [4*17-1:0] prog0;
  logic [4*18-1:0] prog1;
  logic [7:0] rdat0, rdat1;
  logic [3:0] msk0, msk1, req0, req1;
  logic [31:0] mode0, mode1;
  logic [4*16-1:0] cur0o;
  logic [4*17-1:0] cur1o;
  logic [7:0] cmd0, cmd1;

  always_comb
    for (int c = 0; c < 4; c++) begin
      prog0[c*17 +: 17] = 17'(pval[c]);
      prog1[c*18 +: 18] = 18'(pval[c]);
    end

  dmareg_top #(.SHIFT(0)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(idx_q), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wd), .bus_rdata(rdat0), .eng_prog_we(pwe), .eng_prog(prog0),
    .eng_tc(tcv), .eng_mask(msk0), .eng_req(req0), .eng_mode(mode0),
    .eng_cur_addr(cur0o), .ctl_command(cmd0)
  );
  dmareg_top #(.SHIFT(1)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr({idx_q, lsb_q}), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wd), .bus_rdata(rdat1), .eng_prog_we(pwe), .eng_prog(prog1),
    .eng_tc(tcv), .eng_mask(msk1), .eng_req(req1), .eng_mode(mode1),
    .eng_cur_addr(cur1o), .ctl_command(cmd1)
  );

  // reference state
  int bA [4], bC [4], cb [4], prg [4], md [4];
  int msk, rq, tcb, cmdm, ptr;
  int nchk = 0, nfail = 0;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_rd(int sh, int idx);
    int v, ch;
    if (idx < 8) begin
      ch = idx >> 1;
      if (idx & 1) v = (bC[ch] << sh) - prg[ch];
      else if (md[ch] & 32) v = (cb[ch] << sh) - prg[ch];
      else v = (cb[ch] << sh) + prg[ch];
      return (v >> (sh + 8 * ptr)) & 255;
    end
    if (idx == 8)  return (rq << 4) | tcb;
    if (idx == 15) return msk;
    return 0;
  endfunction

  task automatic chk_outs(string tag);
    chk({tag, " mask"}, int'(msk0), msk);
    chk({tag, " mask w"}, int'(msk1), msk);
    chk({tag, " req"}, int'(req0), rq);
    chk({tag, " req w"}, int'(req1), rq);
    chk({tag, " cmd"}, int'(cmd0), cmdm);
    chk({tag, " cmd w"}, int'(cmd1), cmdm);
    for (int c = 0; c < 4; c++) begin
      chk({tag, " mode"}, int'(mode0[c*8 +: 8]), md[c]);
      chk({tag, " mode w"}, int'(mode1[c*8 +: 8]), md[c]);
      chk({tag, " cur"}, int'(cur0o[c*16 +: 16]), cb[c]);
      chk({tag, " cur w"}, int'(cur1o[c*17 +: 17]), cb[c] << 1);
    end
  endtask

  // one bus cycle; applies pending pwe/tcv in the same cycle
  task automatic access(bit is_wr, int idx, int d, string tag);
    int ch;
    @(negedge clk);
    idx_q = 4'(idx); lsb_q = ~lsb_q; wd = 8'(d);
    wr = is_wr; rd = !is_wr;
    #1;
    if (!is_wr) begin
      chk({tag, " rd"}, int'(rdat0), exp_rd(0, idx));
      chk({tag, " rd w"}, int'(rdat1), exp_rd(1, idx));
    end
    @(posedge clk);
    #0.5;
    for (int c = 0; c < 4; c++) if (pwe[c]) prg[c] = pval[c];
    if (idx < 8) begin
      ch = idx >> 1;
      if (is_wr) begin
        if (ptr == 0) begin
          if (idx & 1) bC[ch] = (bC[ch] & 16'hFF00) | d;
          else         bA[ch] = (bA[ch] & 16'hFF00) | d;
        end else begin
          if (idx & 1) bC[ch] = (bC[ch] & 255) | (d << 8);
          else         bA[ch] = (bA[ch] & 255) | (d << 8);
          cb[ch] = bA[ch]; prg[ch] = 0;
        end
      end
      ptr ^= 1;
    end else if (is_wr) begin
      case (idx)
        8:  if ((d & 8'hFB) == 0) cmdm = d;
        9:  begin
              if (d & 4) rq |= (1 << (d & 3)); else rq &= ~(1 << (d & 3));
              tcb &= ~(1 << (d & 3));
            end
        10: if (d & 4) msk |= (1 << (d & 3)); else msk &= ~(1 << (d & 3));
        11: md[d & 3] = d;
        12: ptr = 0;
        14: msk = 0;
        15: msk = d & 15;
        default: ;
      endcase
    end else if (idx == 8) tcb = 0;
    tcb |= tcv;
    if (is_wr && idx == 13) begin ptr = 0; msk = 15; rq = 0; tcb = 0; cmdm = 0; end
    wr = 0; rd = 0; pwe = 0; tcv = 0;
  endtask

  task automatic prog_set(int c, int v);
    @(negedge clk);
    pval[c] = v; pwe[c] = 1;
    @(posedge clk);
    #0.5;
    prg[c] = v; pwe = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin bA[c]=0; bC[c]=0; cb[c]=0; prg[c]=0; md[c]=0; pval[c]=0; end
    msk = 15; rq = 0; tcb = 0; cmdm = 0; ptr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R9 power-on state
    chk_outs("R9 reset");
    access(0, 8, 0, "R9 R10 status after reset");
    access(0, 15, 0, "R9 R10 mask after reset");

    // R1 R2 R3 R4: program and read back every channel register
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 2; r++) begin
          access(1, c*2 + r, (p*61 + c*17 + r*5 + 3) & 255, "R1 R2 lo");
          access(1, c*2 + r, (p*37 + c*29 + r*11 + 128) & 255, "R3 hi");
          chk_outs("R3 reload");
          access(0, c*2 + r, 0, "R2 R4 readback lo");
          access(0, c*2 + r, 0, "R2 R4 readback hi");
        end

    // R4 R8 R12: progress in both directions
    for (int c = 0; c < 4; c++)
      for (int dir = 0; dir < 2; dir++) begin
        access(1, 11, (dir << 5) | 8'h44 | c, "R8 mode");
        chk_outs("R8 mode out");
        prog_set(c, 300 + c*257 + dir*1000);
        for (int r = 0; r < 2; r++) begin
          access(0, c*2 + r, 0, "R4 R12 progress lo");
          access(0, c*2 + r, 0, "R4 R12 progress hi");
        end
      end

    // R12: high write beats concurrent progress load
    prog_set(2, 77);
    access(1, 5, 8'h10, "R12 lo");
    pval[2] = 999; pwe[2] = 1;
    access(1, 5, 8'h22, "R12 collide");
    access(0, 5, 0, "R12 cnt lo");
    access(0, 5, 0, "R12 cnt hi");

    // R5: every command value
    for (int v = 0; v < 256; v++) begin
      access(1, 8, v, "R5 cmd");
      chk("R5 cmd out", int'(cmd0), cmdm);
      chk("R5 cmd out w", int'(cmd1), cmdm);
    end

    // R10: unreadable controller indices
    for (int i = 9; i < 15; i++) access(0, i, 0, "R10 zero read");

    // R7: mask operations
    access(1, 14, 0, "R7 clear all");
    chk_outs("R7 clear");
    for (int c = 0; c < 4; c++) begin
      access(1, 10, 4 | c, "R7 single set");
      chk_outs("R7 set");
      access(0, 15, 0, "R7 mask read");
    end
    for (int c = 0; c < 4; c++) begin
      access(1, 10, c, "R7 single clear");
      access(0, 15, 0, "R7 mask read");
    end
    for (int v = 0; v < 16; v++) begin
      access(1, 15, 8'hA0 | v, "R7 load");
      access(0, 15, 0, "R7 load read");
    end

    // R6 R11: requests and terminal counts
    for (int c = 0; c < 4; c++) begin
      tcv = 4'(1 << c);
      access(1, 9, 4 | c, "R6 req set");
      chk_outs("R6 req");
      access(0, 8, 0, "R6 R11 status");
    end
    tcv = 4'b0101;
    access(0, 15, 0, "R11 pulse");
    tcv = 4'b1010;
    access(0, 8, 0, "R11 read with pulse");
    access(0, 8, 0, "R11 survived");
    tcv = 4'b1111;
    access(0, 12, 0, "R11 pulse");
    access(1, 9, 1, "R6 req clear tc clear");
    chk_outs("R6 req clr");
    access(0, 8, 0, "R6 status");

    // R9: pointer clear
    access(0, 0, 0, "R2 toggle");
    access(1, 12, 0, "R9 ptr clear");
    access(0, 0, 0, "R9 low after clear");
    access(0, 1, 0, "R9 high");

    // R9: master reset
    access(1, 11, 8'h21, "R8 mode");
    access(1, 8, 4, "R5 cmd");
    access(0, 2, 0, "R2 toggle");
    tcv = 4'b0011;
    access(1, 13, 0, "R9 master reset");
    chk_outs("R9 mreset");
    access(0, 8, 0, "R9 status");
    access(0, 2, 0, "R9 ptr low");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule